// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit saturating counters. The table is addressed by the fetch address, with its three lowest bits dropped, XORed with a shift register that holds the outcomes of recently resolved branches. Because the recent outcomes form part of the address, branches whose behaviour depends on earlier branches can learn separate counters for each history pattern.

A fetch stage raises a predict request with the fetch address. One cycle later the block returns the direction and the table index it used. That index travels down the pipe with the branch. When the branch resolves, the back end returns the recorded index and the real outcome. The block then moves that counter one step toward the outcome and shifts the outcome into the history register. With a history length of zero the history register is not built, and the block becomes a plain address-indexed table.

After reset the block spends one cycle per entry writing the weakly-taken value into the whole table. During this sweep, predictions are forced to taken and resolved branches are discarded.

Top module: `hist_dir_pred`

## Requirements
- R1: A predict request sampled on one rising edge gives `pred_valid_o`=1 after the next edge. Alongside it come `pred_idx_o`, the index that was read, and `pred_taken_o`, which is bit 1 of that 2-bit counter (1 means taken). With no request, `pred_valid_o` is 0 after the next edge.
- R2: An accepted update raises the addressed counter by one when `upd_taken_i`=1 and lowers it by one when `upd_taken_i`=0. The counter stops at 3 and at 0 and never wraps.
- R3: Hysteresis: once a counter has reached 3, a single not-taken outcome leaves the prediction taken. A second not-taken outcome in a row makes it not taken.
- R4: Each accepted update shifts `upd_taken_i` into bit 0 of the HIST_W-bit history register and drops the oldest bit. After four updates with outcomes 1,0,1,1 and HIST_W=4, the history reads 4'b1011.
- R5: The index is `pred_pc_i[IDX_W+2:3]` XOR the history, zero-extended to IDX_W bits. Address bits 2:0 and bits above IDX_W+2 have no effect.
- R6: With HIST_W=0 the index equals `pred_pc_i[IDX_W+2:3]` at all times, whatever updates arrive.
- R7: While `rst` is high, `pred_valid_o` is 0. For the first 2^IDX_W edges after `rst` falls, every prediction is taken. After that sweep every counter holds 2'b10 and the history is zero.
- R8: An update that arrives during the sweep is ignored. It changes neither any counter nor the history.
- R9: An update writes the entry named by `upd_idx_i`, whatever the current history is.
- R10: An update accepted on edge k affects predictions requested on edge k+2 or later. A request to the same entry on edge k+1 returns the counter value from before the update.
- R11: Updates to the same entry on consecutive edges all take effect: each one builds on the result of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid_i | input | 1 | Predict request |
| pred_pc_i | input | PC_W | Fetch address of the branch |
| upd_valid_i | input | 1 | Resolved branch present |
| upd_idx_i | input | IDX_W | Index recorded at predict time |
| upd_taken_i | input | 1 | Real outcome, 1 = taken |
| pred_valid_o | output | 1 | Prediction result present |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_idx_o | output | IDX_W | Index used for this prediction |

## Verification
A wrong counter value shows up on `pred_taken_o` only when a later request reads that entry, and only when bit 1 is wrong. For this reason, the stimulus steps entries to and past both saturation limits and reads them back two edges after each update. A corrupted history shows up on `pred_idx_o` on the very next prediction, so the index is compared on every result. Missing forwarding between back-to-back updates to one entry shows up as a lost step, which changes the direction that is read back later.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN   = 2'b00;
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_RESET = 2'b10;

  // Move a counter one step toward the resolved outcome, clamped at both ends.
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == CTR_MAX) ? c : c + 2'd1;
    else    return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/hdp_index.sv
module hdp_index #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             shift_en_i,
  input  logic             shift_bit_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] pc_bits;
  logic             unused_pc;

  assign pc_bits   = pc_i[IDX_W+2:3];
  assign unused_pc = ^{pc_i[PC_W-1:IDX_W+3], pc_i[2:0]};

  generate
    if (HIST_W == 0) begin : g_bimodal
      logic unused_hist;
      assign unused_hist = ^{clk, rst, shift_en_i, shift_bit_i};
      assign idx_o       = pc_bits;
    end else begin : g_global
      logic [HIST_W-1:0] ghr_q;

      always_ff @(posedge clk) begin
        if (rst)             ghr_q <= '0;
        else if (shift_en_i) ghr_q <= HIST_W'({ghr_q, shift_bit_i});
      end

      assign idx_o = pc_bits ^ IDX_W'(ghr_q);

      AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        shift_en_i |=> ghr_q == HIST_W'({$past(ghr_q), $past(shift_bit_i)}));  // R4
      AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en_i |=> $stable(ghr_q));  // R8
    end
  endgenerate

endmodule

// File: rtl/hdp_table.sv
module hdp_table
  import hdp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rda_idx_i,
  output ctr_t             rda_q_o,
  input  logic [IDX_W-1:0] rdb_idx_i,
  output ctr_t             rdb_q_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  ctr_t             wr_data_i,
  output logic             init_o
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t             mem [DEPTH];
  logic             init_q;
  logic [IDX_W-1:0] sweep_q;
  logic             we;
  logic [IDX_W-1:0] wa;
  ctr_t             wd;

  // Post-reset sweep: one entry written per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= 1'b1;
      sweep_q <= '0;
    end else if (init_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == IDX_W'(DEPTH - 1)) init_q <= 1'b0;
    end
  end

  // The sweep owns the single write port.
  assign we = init_q | wr_en_i;
  assign wa = init_q ? sweep_q   : wr_idx_i;
  assign wd = init_q ? CTR_RESET : wr_data_i;

  // Read-first RAM: two registered reads, one write.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rda_q_o <= mem[rda_idx_i];
    rdb_q_o <= mem[rdb_idx_i];
  end

  assign init_o = init_q;

  AST_SWEEP_EXCL: assert property (@(posedge clk) disable iff (rst)
    init_q |-> !wr_en_i);  // R8

endmodule

// File: rtl/hdp_update.sv
module hdp_update
  import hdp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i,
  input  ctr_t             rd_q_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output ctr_t             wr_data_o
);

  logic             s1_vld_q;
  logic [IDX_W-1:0] s1_idx_q;
  logic             s1_taken_q;
  logic             fwd_q;
  ctr_t             fwd_val_q;
  ctr_t             eff_ctr;

  assign accept_o = upd_valid_i & ~init_i;
  assign rd_idx_o = upd_idx_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld_q <= 1'b0;
      fwd_q    <= 1'b0;
    end else begin
      s1_vld_q <= accept_o;
      fwd_q    <= s1_vld_q && (s1_idx_q == upd_idx_i);
    end
    s1_idx_q   <= upd_idx_i;
    s1_taken_q <= upd_taken_i;
    fwd_val_q  <= wr_data_o;
  end

  // The RAM read was taken before the previous write landed; forward that write.
  assign eff_ctr   = fwd_q ? fwd_val_q : rd_q_i;
  assign wr_en_o   = s1_vld_q;
  assign wr_idx_o  = s1_idx_q;
  assign wr_data_o = ctr_step(eff_ctr, s1_taken_q);

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && s1_taken_q) |-> wr_data_o >= eff_ctr);  // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !s1_taken_q) |-> wr_data_o <= eff_ctr);  // R2

endmodule

// File: rtl/hist_dir_pred.sv
module hist_dir_pred
  import hdp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pred_valid_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i,
  output logic             pred_valid_o,
  output logic             pred_taken_o,
  output logic [IDX_W-1:0] pred_idx_o
);

  logic [IDX_W-1:0] idx;
  logic             accept;
  logic             init;
  logic [IDX_W-1:0] rdb_idx;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  ctr_t             wr_data;
  ctr_t             rda_q;
  ctr_t             rdb_q;
  logic             pred_init_q;

  hdp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_index (
    .clk        (clk),
    .rst        (rst),
    .pc_i       (pred_pc_i),
    .shift_en_i (accept),
    .shift_bit_i(upd_taken_i),
    .idx_o      (idx)
  );

  hdp_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rda_idx_i(idx),
    .rda_q_o  (rda_q),
    .rdb_idx_i(rdb_idx),
    .rdb_q_o  (rdb_q),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .init_o   (init)
  );

  hdp_update #(.IDX_W(IDX_W)) u_update (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init),
    .upd_valid_i(upd_valid_i),
    .upd_idx_i  (upd_idx_i),
    .upd_taken_i(upd_taken_i),
    .rd_q_i     (rdb_q),
    .accept_o   (accept),
    .rd_idx_o   (rdb_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid_o <= 1'b0;
      pred_idx_o   <= '0;
      pred_init_q  <= 1'b0;
    end else begin
      pred_valid_o <= pred_valid_i;
      pred_idx_o   <= idx;
      pred_init_q  <= init;
    end
  end

  assign pred_taken_o = pred_init_q | rda_q[1];

  AST_PRED_LAT: assert property (@(posedge clk) disable iff (rst)
    pred_valid_i |=> pred_valid_o);  // R1
  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pred_valid_i |=> !pred_valid_o);  // R1

  generate
    if (HIST_W == 0) begin : g_bim_chk
      AST_BIM_IDX: assert property (@(posedge clk) disable iff (rst)
        pred_valid_i |=> pred_idx_o == $past(pred_pc_i[IDX_W+2:3]));  // R6
    end
  endgenerate

endmodule

// File: tb/hist_dir_pred_bench.sv
module hist_dir_pred_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 32;
  localparam int IDX_W      = 6;
  localparam int HIST_W     = 4;
  localparam int DEPTH      = 1 << IDX_W;
  localparam int HMASK      = (1 << HIST_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic             pv = 0, uv = 0, ut = 0;
  logic [PC_W-1:0]  pc = '0;
  logic [IDX_W-1:0] ui = '0;
  logic             ov, ot;
  logic [IDX_W-1:0] oi;

  logic             b_pv = 0, b_uv = 0, b_ut = 0;
  logic [PC_W-1:0]  b_pc = '0;
  logic [IDX_W-1:0] b_ui = '0;
  logic             b_ov, b_ot;
  logic [IDX_W-1:0] b_oi;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hist_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist_dir_pred (
    .clk(clk), .rst(rst), .pred_valid_i(pv), .pred_pc_i(pc),
    .upd_valid_i(uv), .upd_idx_i(ui), .upd_taken_i(ut),
    .pred_valid_o(ov), .pred_taken_o(ot), .pred_idx_o(oi)
  );

  hist_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(0)) u_hist_dir_pred_bim (
    .clk(clk), .rst(rst), .pred_valid_i(b_pv), .pred_pc_i(b_pc),
    .upd_valid_i(b_uv), .upd_idx_i(b_ui), .upd_taken_i(b_ut),
    .pred_valid_o(b_ov), .pred_taken_o(b_ot), .pred_idx_o(b_oi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  int tbl [DEPTH];
  int ghr_m = 0, n_edge = 0, pend_i = 0, ex_i = 0, m_idx = 0;
  bit pend_v = 0, pend_t = 0, ex_v = 0, ex_t = 0, m_init = 0;

  function automatic int step_ref(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ghr_m = 0; n_edge = 0; pend_v = 0; ex_v = 0;
    end else begin
      m_init = (n_edge < DEPTH);
      m_idx  = ((int'(pc) >> 3) ^ ghr_m) & (DEPTH - 1);
      ex_v   = pv;
      ex_i   = m_idx;
      ex_t   = m_init ? 1'b1 : tbl[m_idx][1];
      if (m_init) tbl[n_edge] = 2;
      if (pend_v) tbl[pend_i] = step_ref(tbl[pend_i], pend_t);
      pend_v = uv && !m_init;
      pend_i = int'(ui);
      pend_t = ut;
      if (uv && !m_init) ghr_m = ((ghr_m << 1) | int'(ut)) & HMASK;
      if (n_edge < DEPTH) n_edge++;
    end
  end

  // Model comparison on every cycle (R1, R10 timing).
  always @(negedge clk) begin
    if (!rst) begin
      check("R1 valid", int'(ov), int'(ex_v));
      if (ex_v) begin
        check("R1 taken", int'(ot), int'(ex_t));
        check("R1 index", int'(oi), ex_i);
      end
    end
  end

  function automatic int pc_for(input int idx);
    return ((idx ^ ghr_m) & (DEPTH - 1)) << 3;
  endfunction

  // One cycle on the main instance; called at a falling edge.
  task automatic cyc(input bit u_v, input int u_i, input bit u_t,
                     input bit p_v, input int p_pc, output bit r_t, output int r_i);
    uv = u_v; ui = IDX_W'(u_i); ut = u_t; pv = p_v; pc = PC_W'(p_pc);
    @(posedge clk);
    @(negedge clk);
    r_t = ot; r_i = int'(oi);
    uv = 0; pv = 0;
  endtask

  task automatic b_cyc(input bit u_v, input int u_i, input bit u_t,
                       input bit p_v, input int p_pc, output bit r_t, output int r_i);
    b_uv = u_v; b_ui = IDX_W'(u_i); b_ut = u_t; b_pv = p_v; b_pc = PC_W'(p_pc);
    @(posedge clk);
    @(negedge clk);
    r_t = b_ot; r_i = int'(b_oi);
    b_uv = 0; b_pv = 0;
  endtask

  initial begin
    bit t;
    int i;
    repeat (3) @(negedge clk);
    check("R7 reset valid", int'(ov), 0);
    check("R7 reset valid bimodal", int'(b_ov), 0);
    rst = 0;

    // During the sweep: forced taken, updates dropped.
    cyc(0, 0, 0, 1, 40, t, i);  check("R7 sweep taken", int'(t), 1);
    cyc(1, 5, 0, 0, 0, t, i);
    cyc(1, 5, 0, 0, 0, t, i);
    cyc(1, 5, 1, 0, 0, t, i);
    repeat (DEPTH + 6) @(negedge clk);
    cyc(0, 0, 0, 1, 40, t, i);
    check("R8 counter untouched", int'(t), 1);
    check("R8 history untouched", i, 5);

    // R10: one-edge-later read sees old value, two edges later sees new.
    cyc(1, 5, 0, 0, 0, t, i);
    cyc(0, 0, 0, 1, 40, t, i);  check("R10 pre-update read", int'(t), 1);
    cyc(0, 0, 0, 1, 40, t, i);  check("R10 post-update read", int'(t), 0);

    // R2 low end: 1 -> 0 -> 0 -> 1 -> 2.
    cyc(1, 5, 0, 0, 0, t, i);
    cyc(1, 5, 0, 0, 0, t, i);
    cyc(1, 5, 1, 0, 0, t, i);
    cyc(1, 5, 1, 0, 0, t, i);
    cyc(0, 0, 0, 0, 0, t, i);
    cyc(0, 0, 0, 1, pc_for(5), t, i);  check("R2 saturate at 0", int'(t), 1);

    // R2 high end and R3 hysteresis on entry 9: 2 -> 3 -> 3 -> 3 -> 2 -> 1.
    cyc(1, 9, 1, 0, 0, t, i);
    cyc(1, 9, 1, 0, 0, t, i);
    cyc(1, 9, 1, 0, 0, t, i);
    cyc(1, 9, 0, 0, 0, t, i);
    cyc(0, 0, 0, 0, 0, t, i);
    cyc(0, 0, 0, 1, pc_for(9), t, i);  check("R2 saturate at 3", int'(t), 1);
    check("R3 single miss keeps taken", int'(t), 1);
    cyc(1, 9, 0, 0, 0, t, i);
    cyc(0, 0, 0, 0, 0, t, i);
    cyc(0, 0, 0, 1, pc_for(9), t, i);  check("R3 second miss flips", int'(t), 0);

    // R11: back-to-back updates to entry 20: 2 -> 1 -> 0 -> 1.
    cyc(1, 20, 0, 0, 0, t, i);
    cyc(1, 20, 0, 0, 0, t, i);
    cyc(1, 20, 1, 0, 0, t, i);
    cyc(0, 0, 0, 0, 0, t, i);
    cyc(0, 0, 0, 1, pc_for(20), t, i);  check("R11 back-to-back", int'(t), 0);

    // R4/R5: history fully replaced by 1,0,1,1.
    cyc(1, 30, 1, 0, 0, t, i);
    cyc(1, 30, 0, 0, 0, t, i);
    cyc(1, 30, 1, 0, 0, t, i);
    cyc(1, 30, 1, 0, 0, t, i);
    cyc(0, 0, 0, 1, 0, t, i);                      check("R4 history 1011", i, 11);
    cyc(0, 0, 0, 1, 63 << 3, t, i);                check("R5 xor hash", i, 52);
    cyc(0, 0, 0, 1, (63 << 3) | 7 | (1 << 20), t, i); check("R5 ignored bits", i, 52);

    // R9: updates land on the recorded index.
    cyc(1, 40, 0, 0, 0, t, i);
    cyc(1, 40, 0, 0, 0, t, i);
    cyc(0, 0, 0, 0, 0, t, i);
    cyc(0, 0, 0, 1, pc_for(40), t, i);
    check("R9 recorded index written", int'(t), 0);
    check("R9 index read back", i, 40);

    // R6: bimodal variant.
    b_cyc(0, 0, 0, 1, 13 << 3, t, i);
    check("R6 bimodal idx", i, 13);
    check("R6 bimodal initial taken", int'(t), 1);
    b_cyc(1, 13, 0, 0, 0, t, i);
    b_cyc(1, 13, 0, 0, 0, t, i);
    b_cyc(0, 0, 0, 0, 0, t, i);
    b_cyc(0, 0, 0, 1, (13 << 3) | (1 << 9), t, i);
    check("R6 bimodal idx after updates", i, 13);
    check("R6 bimodal learned", int'(t), 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule